// File: doc/BRIEF.md
# Gated-Input Serial-to-Parallel Shift Register

This block is an edge-triggered shift register with a parameterized number of stages. Every stage drives its own bit of a parallel output bus. On each rising clock edge the contents move one place toward the most significant stage, and a new bit enters the least significant stage.

The incoming bit is the logical AND of two serial data pins. Either pin therefore works as an active-high enable for the other. When only one pin carries data, the other is tied high.

An active-low clear empties every stage at once. It does not wait for a clock edge, and it overrides both the clock and the data pins. After the clear is released, the register stays all-zero until the next rising edge.

Top module: `gated_sipo`

## Requirements
- R1: While `clr_n` is low, `par_q` reads all zeros.
- R2: On a rising edge of `clk` with `clr_n` high, `par_q[0]` takes the value `ser_a & ser_b` sampled at that edge.
- R3: On the same edge, `par_q[i]` takes the previous `par_q[i-1]` for every i from 1 to STAGES-1, and the previous top bit is lost.
- R4: When either serial pin is low at an edge, a 0 enters `par_q[0]`, whatever the level of the other pin.
- R5: With `ser_b` held high, the bit entering stage 0 equals `ser_a`. A pattern fed in oldest-first therefore appears on `par_q` with its oldest bit in the highest index.
- R6: A falling `clr_n` between clock edges clears `par_q` to zero before any further clock edge.
- R7: Rising clock edges that occur while `clr_n` is low leave `par_q` at zero, even with both serial pins high.
- R8: After `clr_n` rises, `par_q` stays zero until the next rising edge. At that edge only bit 0 can become 1.
- R9: The stage count is the parameter STAGES (default 8), and `par_q[i]` is stage i, counted from the entry stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising-edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| ser_a | input | 1 | Serial data pin, ANDed with `ser_b` |
| ser_b | input | 1 | Serial data pin, ANDed with `ser_a` |
| par_q | output | STAGES | Parallel view of all stages, bit 0 is the entry stage |

## Verification
The bench builds the block with the default STAGES of 8. At that length, a full pattern passes through the whole register in eight edges, so the discard of the top bit and the index order of every stage are reached quickly. Clear pulses are placed between edges and held across an edge, so both the asynchronous clear and the priority of clear over the clock can be observed. Random pin pairs exercise each gating combination against a queue-based reference model.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

    localparam int DEFAULT_STAGES = 8;

    typedef struct packed {
        logic a;
        logic b;
    } ser_pair_t;

    function automatic logic entry_bit(ser_pair_t p);
        return p.a & p.b;
    endfunction

endpackage

// File: rtl/sipo_gate.sv
module sipo_gate
    import sipo_pkg::*;
(
    input  ser_pair_t pins,
    output logic      din
);

    always_comb begin
        din = entry_bit(pins);
    end

endmodule

// File: rtl/sipo_cell.sv
module sipo_cell (
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/sipo_chain.sv
module sipo_chain #(
    parameter int STAGES = sipo_pkg::DEFAULT_STAGES
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              din,
    output logic [STAGES-1:0] q
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g <= LAST; g++) begin : g_stage
        if (g == 0) begin : g_entry
            sipo_cell u_cell (
                .clk   (clk),
                .clr_n (clr_n),
                .d     (din),
                .q     (q[g])
            );
        end else begin : g_link
            sipo_cell u_cell (
                .clk   (clk),
                .clr_n (clr_n),
                .d     (q[g-1]),
                .q     (q[g])
            );

            AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!clr_n)
                $past(clr_n) |-> (q[g] == $past(q[g-1]))); // R3
        end
    end

endmodule

// File: rtl/gated_sipo.sv
module gated_sipo
    import sipo_pkg::*;
#(
    parameter int STAGES = DEFAULT_STAGES
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              ser_a,
    input  logic              ser_b,
    output logic [STAGES-1:0] par_q
);

    localparam int UPPER = STAGES - 1;

    ser_pair_t pins;
    logic      din;

    always_comb begin
        pins.a = ser_a;
        pins.b = ser_b;
    end

    sipo_gate u_gate (
        .pins (pins),
        .din  (din)
    );

    sipo_chain #(.STAGES(STAGES)) u_chain (
        .clk   (clk),
        .clr_n (clr_n),
        .din   (din),
        .q     (par_q)
    );

    AST_CLEAR_EMPTY: assert property (@(negedge clk)
        (!clr_n) |-> (par_q == '0)); // R1

    AST_ENTRY_BIT: assert property (@(posedge clk) disable iff (!clr_n)
        $past(clr_n) |-> (par_q[0] == ($past(ser_a) & $past(ser_b)))); // R2

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(clr_n) && !($past(ser_a) && $past(ser_b))) |-> !par_q[0]); // R4

    AST_RELEASE_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        !$past(clr_n) |-> (par_q[UPPER:1] == '0)); // R8

endmodule

// File: tb/gated_sipo_test.sv
`timescale 1ns/1ps
module gated_sipo_test;

    localparam int STAGES = 8;
    localparam real HALF = 4.0;

    logic clk = 1'b0;
    logic clr_n = 1'b0;
    logic ser_a = 1'b0;
    logic ser_b = 1'b0;
    logic [STAGES-1:0] par_q;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit mdl[$];

    gated_sipo #(.STAGES(STAGES)) uut (
        .clk   (clk),
        .clr_n (clr_n),
        .ser_a (ser_a),
        .ser_b (ser_b),
        .par_q (par_q)
    );

    always #(HALF) clk = ~clk;

    function automatic logic [STAGES-1:0] model_vec();
        logic [STAGES-1:0] v = '0;
        for (int i = 0; i < STAGES; i++) v[i] = mdl[i];
        return v;
    endfunction

    task automatic chk(string tag, logic [STAGES-1:0] act, logic [STAGES-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < STAGES; i++) mdl.push_back(1'b0);
    end

    // reference model: queue, index 0 is the entry stage
    always @(posedge clk) begin
        if (clr_n) begin
            mdl.push_front(ser_a & ser_b);
            void'(mdl.pop_back());
        end
    end

    always @(negedge clr_n) begin
        for (int i = 0; i < STAGES; i++) mdl[i] = 1'b0;
    end

    always @(negedge clk) begin
        if (!done) chk("R2 R3 model compare", par_q, model_vec());
    end

    initial begin
        #(2.0 * HALF * 20000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] seq;
        logic [STAGES-1:0] exp;
        seq = 8'b1011_0010;

        repeat (3) @(negedge clk);
        #1 chk("R1 reset state", par_q, '0);
        #1 clr_n = 1'b1;

        // R5 / R9: pattern oldest-first with ser_b tied high
        ser_b = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ser_a = seq[i];
        end
        @(negedge clk);
        exp = '0;
        for (int i = 0; i < 8; i++) exp[7-i] = seq[i];
        #1 chk("R5 R9 pattern order", par_q, exp);

        // R3: one more zero, top bit discarded
        ser_a = 1'b0;
        @(negedge clk);
        #1 chk("R3 top bit discarded", par_q, {exp[STAGES-2:0], 1'b0});

        // R4: ser_b low gates ser_a
        ser_a = 1'b1; ser_b = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk("R4 ser_b low gates", {5'b0, par_q[2:0]}, '0);
        ser_a = 1'b0; ser_b = 1'b1;
        repeat (3) @(negedge clk);
        #1 chk("R4 ser_a low gates", {5'b0, par_q[2:0]}, '0);

        // fill with ones, then clear between edges
        ser_a = 1'b1; ser_b = 1'b1;
        repeat (2) @(negedge clk);
        #1 chk("R2 ones entered", {6'b0, par_q[1:0]}, 8'b0000_0011);
        #1 clr_n = 1'b0;
        #1 chk("R6 async clear mid cycle", par_q, '0);
        @(negedge clk);
        #1 chk("R7 edge during clear ignored", par_q, '0);
        #1 clr_n = 1'b1;
        #1 chk("R8 zero after release", par_q, '0);
        @(negedge clk);
        #1 chk("R8 first edge loads bit0", par_q, 8'b0000_0001);

        // random phase with clear pulses spanning an edge
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            ser_a = 1'($urandom_range(0, 1));
            ser_b = 1'($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 29) == 0) begin
                #2 clr_n = 1'b0;
                #1 chk("R6 random clear", par_q, '0);
                @(negedge clk);
                #1 chk("R7 random clear held", par_q, '0);
                #1 clr_n = 1'b1;
            end
        end

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule